// File: doc/BRIEF.md
# Combined LFSR and Shift-Register Pattern Generator

This block produces test vectors for pseudoexhaustive self-test of a small combinational circuit. An autonomous maximal-length LFSR drives the first inputs of the circuit under test. A plain shift-register tail with no feedback takes the last LFSR stage and drives the remaining inputs. The result is that every window of adjacent inputs, up to the dependency width, sees all of its value combinations. The hardware is cheaper than a constant-weight counter, at the price of a somewhat longer test.

The default configuration has four stages and targets a 4-input circuit whose outputs each depend on at most 2 inputs. The LFSR section is three stages with period 7, and the tail is one flip-flop. A seed strobe writes all stages in one cycle. A test run is normally started from two seeds, because one seed alone is not guaranteed to cover every required combination. An all-zero LFSR seed would lock the register, so it is replaced by a fixed nonzero default.

Top module: `lfsrShiftPatternGen`

## Requirements
- R1: After reset the vector is 4'b0001, where bit 0 is input x1 and bit 3 is input x4.
- R2: On a clock with enable high and no seed load, the LFSR section (bits 0..2) advances: new bit 0 = old bit 1 XOR old bit 2, new bit 1 = old bit 0, new bit 2 = old bit 1.
- R3: The LFSR section is never all zero. Stepped from any nonzero state, it visits all 7 nonzero states and returns to its start after exactly 7 steps.
- R4: On each step, tail bit 3 takes the value that bit 2 held before the step.
- R5: With enable low and no seed load, the whole vector holds its value.
- R6: A seed load with nonzero seed bits 0..2 makes the next vector equal to the seed, whatever the level of enable (the load takes priority over stepping).
- R7: A seed load whose bits 0..2 are all zero sets the LFSR section to 3'b001 and still loads tail bit 3 from seed bit 3.
- R8: Over the vectors stepped from two seeds, each adjacent input pair (x1,x2), (x2,x3) and (x3,x4) takes all four value combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | Strobe that writes the seed into all stages |
| seedValue | input | 4 | Seed; bit 0 is x1 |
| enable | input | 1 | Advances the generator by one pattern |
| testVector | output | 4 | Pattern applied to the circuit under test; bit 0 is x1 |

## Verification
The assertions check on every cycle that the LFSR section never reaches zero, that the tail follows the last LFSR stage, that the vector holds when the generator is idle, and that seed loads, including the zero-seed substitution, take effect on the next cycle. Only the bench's scenarios can show properties of whole sequences: the period-7 cycle through all nonzero states, the exact values after reset and after each step, and that the vector streams from two seeds together cover every adjacent pair combination.

// File: rtl/lfsrShiftPkg.sv
`timescale 1ns/1ps
package lfsrShiftPkg;
  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic load;         // write the seed this cycle
    logic forceDefault; // seed LFSR part was zero: use the default instead
    logic advance;      // step the generator this cycle
  } genCtrl_t;
endpackage

// File: rtl/lfsrShiftCtrl.sv
`timescale 1ns/1ps
module lfsrShiftCtrl
  import lfsrShiftPkg::*;
#(
  parameter int LFSR_W = 3,
  parameter int TAIL_W = 1,
  localparam int VEC_W = LFSR_W + TAIL_W
) (
  input  logic             seedLoad,
  input  logic [VEC_W-1:0] seedValue,
  input  logic             enable,
  output genCtrl_t         strobes
);
  logic seedLfsrZero;

  always_comb begin
    seedLfsrZero         = (seedValue[LFSR_W-1:0] == '0);
    strobes.load         = seedLoad;
    strobes.forceDefault = seedLoad & seedLfsrZero;
    strobes.advance      = enable & ~seedLoad;
  end
endmodule

// File: rtl/lfsrShiftDatapath.sv
`timescale 1ns/1ps
module lfsrShiftDatapath
  import lfsrShiftPkg::*;
#(
  parameter int               LFSR_W       = 3,
  parameter int               TAIL_W       = 1,
  parameter logic [LFSR_W-1:0] TAP_MASK    = 3'b110,
  parameter logic [LFSR_W-1:0] LFSR_DEFAULT = 3'b001,
  localparam int VEC_W = LFSR_W + TAIL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  genCtrl_t         strobes,
  input  logic [VEC_W-1:0] seedValue,
  output logic [VEC_W-1:0] vecOut
);
  logic [LFSR_W-1:0] lfsrQ;
  logic [TAIL_W-1:0] tailQ;
  logic              feedBit;

  assign feedBit = ^(lfsrQ & TAP_MASK);

  // LFSR section: stage 0 takes the feedback, higher stages shift up
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= LFSR_DEFAULT;
    end else if (strobes.load) begin
      lfsrQ <= strobes.forceDefault ? LFSR_DEFAULT : seedValue[LFSR_W-1:0];
    end else if (strobes.advance) begin
      lfsrQ <= {lfsrQ[LFSR_W-2:0], feedBit};
    end
  end

  // Tail: plain shift register fed by the last LFSR stage
  generate
    for (genvar k = 0; k < TAIL_W; k++) begin : gTail
      always_ff @(posedge clk) begin
        if (!rstN) begin
          tailQ[k] <= 1'b0;
        end else if (strobes.load) begin
          tailQ[k] <= seedValue[LFSR_W + k];
        end else if (strobes.advance) begin
          if (k == 0) tailQ[k] <= lfsrQ[LFSR_W-1];
          else        tailQ[k] <= tailQ[(k == 0) ? 0 : k-1];
        end
      end
    end
  endgenerate

  assign vecOut = {tailQ, lfsrQ};

  // R3: the LFSR section never sits at zero
  p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    vecOut[LFSR_W-1:0] != '0);

  // R4: the first tail stage follows the last LFSR stage on a step
  p_tail_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> vecOut[LFSR_W] == $past(vecOut[LFSR_W-1]));

  // R5: idle generator holds its vector
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.load) |=> $stable(vecOut));

  // R6: nonzero seed is taken as given
  p_seed_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.forceDefault) |=> vecOut == $past(seedValue));

  // R7: zero LFSR seed is replaced by the default, tail still loaded
  p_zero_seed_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceDefault |=>
      (vecOut[LFSR_W-1:0] == LFSR_DEFAULT) &&
      (vecOut[VEC_W-1:LFSR_W] == $past(seedValue[VEC_W-1:LFSR_W])));
endmodule

// File: rtl/lfsrShiftPatternGen.sv
`timescale 1ns/1ps
module lfsrShiftPatternGen
  import lfsrShiftPkg::*;
#(
  parameter int               LFSR_W       = 3,
  parameter int               TAIL_W       = 1,
  parameter logic [LFSR_W-1:0] TAP_MASK    = 3'b110,
  parameter logic [LFSR_W-1:0] LFSR_DEFAULT = 3'b001,
  localparam int VEC_W = LFSR_W + TAIL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seedLoad,
  input  logic [VEC_W-1:0] seedValue,
  input  logic             enable,
  output logic [VEC_W-1:0] testVector
);
  genCtrl_t strobes;

  lfsrShiftCtrl #(.LFSR_W(LFSR_W), .TAIL_W(TAIL_W)) uCtrl (
    .seedLoad (seedLoad),
    .seedValue(seedValue),
    .enable   (enable),
    .strobes  (strobes)
  );

  lfsrShiftDatapath #(
    .LFSR_W(LFSR_W), .TAIL_W(TAIL_W),
    .TAP_MASK(TAP_MASK), .LFSR_DEFAULT(LFSR_DEFAULT)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .seedValue(seedValue),
    .vecOut   (testVector)
  );
endmodule

// File: tb/lfsrShiftPatternGen_test.sv
`timescale 1ns/1ps
module lfsrShiftPatternGen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       seedLoad = 1'b0;
  logic [3:0] seedValue = 4'b0000;
  logic       enable = 1'b0;
  logic [3:0] testVector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] pairSeen [3];

  always #4 clk = ~clk;

  lfsrShiftPatternGen uut (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad),
    .seedValue(seedValue), .enable(enable), .testVector(testVector)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Expected next vector, computed from R2 and R4
  function automatic logic [3:0] nextVec(input logic [3:0] v);
    return {v[2], v[1], v[0], v[1] ^ v[2]};
  endfunction

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic notePairs(input logic [3:0] v);
    for (int p = 0; p < 3; p++) pairSeen[p][{v[p+1], v[p]}] = 1'b1;
  endtask

  task automatic finish;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [3:0] expV;
    logic [7:0] visited;
    for (int p = 0; p < 3; p++) pairSeen[p] = '0;

    tick(); tick();
    rstN = 1'b1;
    tick();
    check("R1 reset vector", testVector, 4'b0001);

    // R2/R4 stepping, R3 period and state coverage
    enable = 1'b1;
    expV = testVector;
    visited = '0;
    for (int s = 0; s < 7; s++) begin
      visited[testVector[2:0]] = 1'b1;
      tick();
      expV = nextVec(expV);
      check("R2 R4 step", testVector, expV);
    end
    check("R3 all nonzero states", {3'b0, visited == 8'hFE}, 4'b0001);
    check("R3 period 7", {1'b0, testVector[2:0]}, 4'b0001);

    // R5 hold
    enable = 1'b0;
    expV = testVector;
    for (int s = 0; s < 3; s++) begin
      tick();
      check("R5 hold", testVector, expV);
    end

    // R6 load beats enable; then R8 pattern from first seed
    enable = 1'b1; seedLoad = 1'b1; seedValue = 4'b1010;
    tick();
    seedLoad = 1'b0;
    check("R6 seed with enable", testVector, 4'b1010);
    expV = testVector;
    for (int s = 0; s < 7; s++) begin
      notePairs(testVector);
      tick();
      expV = nextVec(expV);
      check("R2 R4 seed one run", testVector, expV);
    end

    // R7 zero LFSR seed, then R8 from second seed
    seedLoad = 1'b1; seedValue = 4'b1000;
    tick();
    seedLoad = 1'b0;
    check("R7 zero seed default", testVector, 4'b1001);
    expV = testVector;
    for (int s = 0; s < 7; s++) begin
      notePairs(testVector);
      tick();
      expV = nextVec(expV);
      check("R3 seed two run", testVector, expV);
    end
    for (int p = 0; p < 3; p++)
      check("R8 pair coverage", pairSeen[p], 4'b1111);

    // R6 load with enable low
    enable = 1'b0; seedLoad = 1'b1; seedValue = 4'b0110;
    tick();
    seedLoad = 1'b0;
    check("R6 seed without enable", testVector, 4'b0110);
    tick();
    check("R5 hold after load", testVector, 4'b0110);

    finish();
  end
endmodule